// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block is the counting core of a real-time clock. A 128 Hz enable pulse advances a 7-bit binary sub-second prescaler. Each time the prescaler wraps, the seconds field advances by one. Seconds, minutes, hours, weekday, day of month, month and two-digit year are kept as packed BCD bytes. A carry ripples through them, and the day-of-month rollover follows the month length and the leap year.

Software reaches the block through a byte-wide indexed register port. Writes are synchronous and reads are combinational. Each advance of the seconds field sets a sticky carry flag. A reader clears the flag, reads all the time bytes, and then checks the flag again. If the flag is set, the read may be torn and is repeated. The flag, gated by its enable, drives a level interrupt. A separate request rounds the seconds to the nearest minute.

Top module: `rtc_core`

## Requirements
- R1: After reset the seconds, minutes, hours, weekday and year read 0x00, the day and month read 0x01, the sub-second counter reads 0, control 1 reads 0x00, control 2 reads 0x02 and `carryIrq` is low.
- R2: The register indices are fixed: 0 sub-second, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day, 6 month, 7 year, 14 control 1, 15 control 2. The sub-second register (7 bits, zero-extended) ignores writes. Indices 8 to 13 read 0x00 and ignore writes.
- R3: Control 2 has enable at bit 3, prescaler reset at bit 1 and start at bit 0. The sub-second counter increments on each `tick128` pulse only while enable=1, start=1 and prescaler reset=0. Otherwise it holds its value. Prescaler reset=1 forces it to 0.
- R4: A wrap of the sub-second counter from 127 to 0 advances the seconds in BCD. Seconds carry at 59 into minutes, minutes carry at 59 into hours, and hours carry at 23 into both the day and the weekday. The weekday wraps from 6 to 0.
- R5: The day of month wraps to 01 after 31, except after 30 in months 04, 06, 09 and 11. In month 02 it wraps after 28, or after 29 when the year's value is divisible by 4 (00 counts).
- R6: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R7: Writes to indices 1 to 7 take effect only while start=0 and prescaler reset=1. At any other time they are ignored.
- R8: Control 1 bit 7 is the carry flag. It is set whenever the seconds field advances from a prescaler wrap. Writing control 1 with bit 7 = 0 clears it, and writing bit 7 = 1 leaves it unchanged.
- R9: Control 1 bit 4 is the carry interrupt enable. `carryIrq` is high exactly while both the flag and the enable are 1.
- R10: Writing control 2 with bit 2 = 1 posts a rounding request, and bit 2 reads 1 while the request is pending. On the next counted `tick128`, seconds 00–29 become 00 and seconds 30–59 become 00 with a carry into minutes. The same tick zeroes the sub-second counter, and the request then clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick128 | input | 1 | One-cycle 128 Hz count enable |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register index for read and write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data at `regAddr` |
| carryIrq | output | 1 | Carry interrupt level |

## Verification
The rollover chain is driven from preloaded times, each followed by exactly 128 counted ticks. The cases are:
- a plain ones-digit step and a ones-to-tens BCD step, which show a BCD increment is not a binary one;
- minute, hour and day carries;
- 30-day, 31-day and February ends in common and leap years, including year 00, which pin down the month-length table;
- a December 31st of year 99, which shows both wraps.

Further stimulus separates the three gating bits of the prescaler, and writes made while running, which must not land. The carry flag is watched one tick before and at the wrap, to prove it marks exactly the seconds advance. The rounding request is tried on either side of 30 seconds.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_AW = 4;
  localparam int BYTE_W = 8;

  localparam logic [REG_AW-1:0] IDX_SUB  = 4'd0;
  localparam logic [REG_AW-1:0] IDX_SEC  = 4'd1;
  localparam logic [REG_AW-1:0] IDX_MIN  = 4'd2;
  localparam logic [REG_AW-1:0] IDX_HR   = 4'd3;
  localparam logic [REG_AW-1:0] IDX_WK   = 4'd4;
  localparam logic [REG_AW-1:0] IDX_DAY  = 4'd5;
  localparam logic [REG_AW-1:0] IDX_MON  = 4'd6;
  localparam logic [REG_AW-1:0] IDX_YR   = 4'd7;
  localparam logic [REG_AW-1:0] IDX_CTL1 = 4'd14;
  localparam logic [REG_AW-1:0] IDX_CTL2 = 4'd15;

  localparam int FLAG_BIT  = 7;
  localparam int CIE_BIT   = 4;
  localparam int EN_BIT    = 3;
  localparam int ADJ_BIT   = 2;
  localparam int PRST_BIT  = 1;
  localparam int START_BIT = 0;

  typedef struct packed {
    logic secTick;
    logic adjApply;
    logic loadEn;
  } tickStrobes_t;

  typedef struct packed {
    logic [BYTE_W-1:0] sec;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] hr;
    logic [BYTE_W-1:0] wk;
    logic [BYTE_W-1:0] day;
    logic [BYTE_W-1:0] mon;
    logic [BYTE_W-1:0] yr;
  } timeFields_t;

  // Packed BCD +1 without wrap; the caller handles the field limit.
  function automatic logic [BYTE_W-1:0] bcdNext(input logic [BYTE_W-1:0] v);
    if (v[3:0] >= 4'd9) bcdNext = {v[7:4] + 4'd1, 4'd0};
    else                bcdNext = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Last BCD day of the given BCD month; leap when the year value is a multiple of 4.
  function automatic logic [BYTE_W-1:0] lastDay(input logic [BYTE_W-1:0] mon,
                                                input logic [BYTE_W-1:0] yr);
    logic [6:0] yrBin;
    yrBin = {3'b000, yr[7:4]} * 7'd10 + {3'b000, yr[3:0]};
    case (mon)
      8'h02:                      lastDay = (yrBin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: lastDay = 8'h30;
      default:                    lastDay = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int SUB_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick128,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  output tickStrobes_t      strobes,
  output logic [SUB_W-1:0]  subCount,
  output logic [BYTE_W-1:0] ctl1Val,
  output logic [BYTE_W-1:0] ctl2Val,
  output logic              carryIrq
);
  localparam logic [SUB_W-1:0] SUB_LAST = '1;

  logic enBit, startBit, prstBit, adjPend, carryFlag, cieBit;
  logic wrCtl1, wrCtl2, running, tickLive;
  logic unusedWr;

  assign wrCtl1   = wrEn && (wrAddr == IDX_CTL1);
  assign wrCtl2   = wrEn && (wrAddr == IDX_CTL2);
  assign running  = enBit & startBit & ~prstBit;
  assign tickLive = tick128 & running;
  assign unusedWr = ^wrData[6:5];

  assign strobes.secTick  = tickLive & ~adjPend & (subCount == SUB_LAST);
  assign strobes.adjApply = tickLive & adjPend;
  assign strobes.loadEn   = ~startBit & prstBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBit    <= 1'b0;
      startBit <= 1'b0;
      prstBit  <= 1'b1;
      adjPend  <= 1'b0;
    end else begin
      if (wrCtl2) begin
        enBit    <= wrData[EN_BIT];
        startBit <= wrData[START_BIT];
        prstBit  <= wrData[PRST_BIT];
      end
      if (wrCtl2 && wrData[ADJ_BIT]) adjPend <= 1'b1;
      else if (strobes.adjApply)     adjPend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 subCount <= '0;
    else if (prstBit)          subCount <= '0;
    else if (strobes.adjApply) subCount <= '0;
    else if (tickLive)         subCount <= subCount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carryFlag <= 1'b0;
      cieBit    <= 1'b0;
    end else begin
      if (wrCtl1) cieBit <= wrData[CIE_BIT];
      if (strobes.secTick)                  carryFlag <= 1'b1;
      else if (wrCtl1 && !wrData[FLAG_BIT]) carryFlag <= 1'b0;
    end
  end

  assign carryIrq = carryFlag & cieBit;
  assign ctl1Val  = {carryFlag, 2'b00, cieBit, 4'b0000};
  assign ctl2Val  = {4'b0000, enBit, adjPend, prstBit, startBit};
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tickStrobes_t      strobes,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  output timeFields_t       curTime
);
  logic secWrap, minIn, hrIn, dayIn, monIn, yrIn, load;
  logic [BYTE_W-1:0] monthEnd;

  assign monthEnd = lastDay(curTime.mon, curTime.yr);
  assign secWrap  = strobes.secTick & (curTime.sec == 8'h59);
  assign minIn    = secWrap | (strobes.adjApply & (curTime.sec >= 8'h30));
  assign hrIn     = minIn & (curTime.min == 8'h59);
  assign dayIn    = hrIn  & (curTime.hr  == 8'h23);
  assign monIn    = dayIn & (curTime.day == monthEnd);
  assign yrIn     = monIn & (curTime.mon == 8'h12);
  assign load     = wrEn & strobes.loadEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curTime <= '{sec: 8'h00, min: 8'h00, hr: 8'h00, wk: 8'h00,
                   day: 8'h01, mon: 8'h01, yr: 8'h00};
    end else if (load) begin
      case (wrAddr)
        IDX_SEC: curTime.sec <= wrData;
        IDX_MIN: curTime.min <= wrData;
        IDX_HR:  curTime.hr  <= wrData;
        IDX_WK:  curTime.wk  <= wrData;
        IDX_DAY: curTime.day <= wrData;
        IDX_MON: curTime.mon <= wrData;
        IDX_YR:  curTime.yr  <= wrData;
        default: ;
      endcase
    end else begin
      if (strobes.adjApply)     curTime.sec <= 8'h00;
      else if (strobes.secTick) curTime.sec <= secWrap ? 8'h00 : bcdNext(curTime.sec);
      if (minIn) curTime.min <= (curTime.min == 8'h59) ? 8'h00 : bcdNext(curTime.min);
      if (hrIn)  curTime.hr  <= (curTime.hr  == 8'h23) ? 8'h00 : bcdNext(curTime.hr);
      if (dayIn) begin
        curTime.wk  <= (curTime.wk == 8'h06) ? 8'h00 : bcdNext(curTime.wk);
        curTime.day <= (curTime.day == monthEnd) ? 8'h01 : bcdNext(curTime.day);
      end
      if (monIn) curTime.mon <= (curTime.mon == 8'h12) ? 8'h01 : bcdNext(curTime.mon);
      if (yrIn)  curTime.yr  <= (curTime.yr  == 8'h99) ? 8'h00 : bcdNext(curTime.yr);
    end
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int SUB_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick128,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  output logic              carryIrq
);
  localparam int SUB_PAD = BYTE_W - SUB_W;

  tickStrobes_t      strobes;
  timeFields_t       curTime;
  logic [SUB_W-1:0]  subCount;
  logic [BYTE_W-1:0] ctl1Val, ctl2Val;

  rtc_ctrl #(.SUB_W(SUB_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick128(tick128),
    .wrEn(regWrEn), .wrAddr(regAddr), .wrData(regWrData),
    .strobes(strobes), .subCount(subCount),
    .ctl1Val(ctl1Val), .ctl2Val(ctl2Val), .carryIrq(carryIrq)
  );

  rtc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrEn(regWrEn), .wrAddr(regAddr), .wrData(regWrData),
    .curTime(curTime)
  );

  always_comb begin
    case (regAddr)
      IDX_SUB:  regRdData = {{SUB_PAD{1'b0}}, subCount};
      IDX_SEC:  regRdData = curTime.sec;
      IDX_MIN:  regRdData = curTime.min;
      IDX_HR:   regRdData = curTime.hr;
      IDX_WK:   regRdData = curTime.wk;
      IDX_DAY:  regRdData = curTime.day;
      IDX_MON:  regRdData = curTime.mon;
      IDX_YR:   regRdData = curTime.yr;
      IDX_CTL1: regRdData = ctl1Val;
      IDX_CTL2: regRdData = ctl2Val;
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
  import rtc_pkg::*;
#(
  parameter int SUB_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick128,
  input tickStrobes_t      strobes,
  input logic [SUB_W-1:0]  subCount,
  input logic [BYTE_W-1:0] ctl1Val,
  input logic [BYTE_W-1:0] ctl2Val,
  input logic [BYTE_W-1:0] secVal
);
  // R3
  sub_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tick128 && !ctl2Val[PRST_BIT]) |=> $stable(subCount));

  // R4
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.secTick && secVal == 8'h59) |=> (secVal == 8'h00));

  // R7
  sec_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadEn && !strobes.secTick && !strobes.adjApply) |=> $stable(secVal));

  // R8
  carry_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.secTick |=> ctl1Val[FLAG_BIT]);

  // R10
  adj_round_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.adjApply |=> (secVal == 8'h00 && subCount == '0 && !ctl2Val[ADJ_BIT]));
endmodule

bind rtc_core rtc_core_chk #(.SUB_W(SUB_W)) u_chk (
  .clk(clk), .rstN(rstN), .tick128(tick128), .strobes(strobes),
  .subCount(subCount), .ctl1Val(ctl1Val), .ctl2Val(ctl2Val),
  .secVal(curTime.sec)
);

// File: tb/rtc_core_bench.sv
module rtc_core_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick128 = 1'b0;
  logic       regWrEn = 1'b0;
  logic [3:0] regAddr = 4'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       carryIrq;
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  rtc_core u_rtc_core (
    .clk(clk), .rstN(rstN), .tick128(tick128), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .carryIrq(carryIrq)
  );

  // {start sec,min,hr,wk,day,mon,yr, expected after one second sec,min,hr,wk,day,mon,yr}
  localparam int NV = 15;
  localparam logic [111:0] VEC [NV] = '{
    {56'h05_00_00_02_10_03_24, 56'h06_00_00_02_10_03_24},
    {56'h09_00_00_02_10_03_24, 56'h10_00_00_02_10_03_24},
    {56'h59_59_00_01_05_06_10, 56'h00_00_01_01_05_06_10},
    {56'h59_59_23_06_30_04_21, 56'h00_00_00_00_01_05_21},
    {56'h59_59_23_03_28_02_23, 56'h00_00_00_04_01_03_23},
    {56'h59_59_23_03_28_02_24, 56'h00_00_00_04_29_02_24},
    {56'h59_59_23_05_29_02_24, 56'h00_00_00_06_01_03_24},
    {56'h59_59_23_00_31_12_99, 56'h00_00_00_01_01_01_00},
    {56'h59_59_23_02_30_01_05, 56'h00_00_00_03_31_01_05},
    {56'h59_59_23_04_31_07_19, 56'h00_00_00_05_01_08_19},
    {56'h19_09_09_01_15_10_30, 56'h20_09_09_01_15_10_30},
    {56'h59_59_23_01_30_11_00, 56'h00_00_00_02_01_12_00},
    {56'h59_59_23_01_28_02_00, 56'h00_00_00_02_29_02_00},
    {56'h59_59_23_01_28_02_02, 56'h00_00_00_02_01_03_02},
    {56'h59_59_09_01_01_01_01, 56'h00_00_10_01_01_01_01}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic expReg(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    regAddr = a;
    #1;
    check(req, regRdData, exp);
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    tick128 = 1'b1;
    repeat (n) @(negedge clk);
    tick128 = 1'b0;
  endtask

  task automatic loadTime(input logic [55:0] t);
    wr(4'd15, 8'h0A);
    for (int i = 0; i < 7; i++) wr(4'(i + 1), t[55 - 8*i -: 8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expReg(4'd0, 8'h00, "R1 sub");
    expReg(4'd1, 8'h00, "R1 sec");
    expReg(4'd2, 8'h00, "R1 min");
    expReg(4'd3, 8'h00, "R1 hr");
    expReg(4'd4, 8'h00, "R1 wk");
    expReg(4'd5, 8'h01, "R1 day");
    expReg(4'd6, 8'h01, "R1 mon");
    expReg(4'd7, 8'h00, "R1 yr");
    expReg(4'd14, 8'h00, "R1 ctl1");
    expReg(4'd15, 8'h02, "R1 ctl2");
    check("R1 irq", {7'd0, carryIrq}, 8'h00);

    // R2 map: unused indices and read-only sub-second
    wr(4'd10, 8'h55);
    expReg(4'd10, 8'h00, "R2 unused index");
    wr(4'd0, 8'h40);
    expReg(4'd0, 8'h00, "R2 sub read-only");

    // R4 R5 R6 rollover table
    for (int v = 0; v < NV; v++) begin
      loadTime(VEC[v][111:56]);
      wr(4'd14, 8'h00);
      wr(4'd15, 8'h09);
      pulse(128);
      for (int i = 0; i < 7; i++)
        expReg(4'(i + 1), VEC[v][55 - 8*i -: 8], $sformatf("R4/R5/R6 vec %0d field %0d", v, i));
      expReg(4'd14, 8'h80, $sformatf("R8 vec %0d flag", v));
      expReg(4'd0, 8'h00, $sformatf("R3 vec %0d sub wrapped", v));
    end

    // R7 writes ignored unless stopped with prescaler reset
    loadTime(56'h12_00_00_00_01_01_00);
    wr(4'd15, 8'h09);
    wr(4'd1, 8'h33);
    expReg(4'd1, 8'h12, "R7 write while running");
    wr(4'd15, 8'h08);
    wr(4'd1, 8'h44);
    expReg(4'd1, 8'h12, "R7 write stopped without reset");

    // R3 prescaler gating
    wr(4'd15, 8'h09);
    pulse(50);
    expReg(4'd0, 8'd50, "R3 counting");
    wr(4'd15, 8'h01);
    pulse(10);
    expReg(4'd0, 8'd50, "R3 enable off holds");
    wr(4'd15, 8'h0B);
    expReg(4'd0, 8'd0, "R3 prescaler reset clears");
    pulse(5);
    expReg(4'd0, 8'd0, "R3 prescaler reset holds");
    expReg(4'd15, 8'h0B, "R3 ctl2 readback");

    // R8 R9 carry flag and interrupt
    loadTime(56'h00_00_00_00_01_01_00);
    wr(4'd14, 8'h10);
    check("R9 irq low after clear", {7'd0, carryIrq}, 8'h00);
    wr(4'd15, 8'h09);
    pulse(127);
    expReg(4'd14, 8'h10, "R8 flag clear before wrap");
    pulse(1);
    expReg(4'd14, 8'h90, "R8 flag set at wrap");
    expReg(4'd1, 8'h01, "R4 seconds advanced");
    check("R9 irq high", {7'd0, carryIrq}, 8'h01);
    wr(4'd14, 8'h90);
    expReg(4'd14, 8'h90, "R8 writing one keeps flag");
    wr(4'd14, 8'h80);
    check("R9 irq masked", {7'd0, carryIrq}, 8'h00);
    expReg(4'd14, 8'h80, "R8 flag kept when masked");
    wr(4'd14, 8'h10);
    expReg(4'd14, 8'h10, "R8 flag cleared by zero");
    check("R9 irq after clear", {7'd0, carryIrq}, 8'h00);

    // R10 rounding request
    loadTime(56'h29_10_07_00_01_01_00);
    wr(4'd15, 8'h09);
    pulse(20);
    wr(4'd15, 8'h0D);
    expReg(4'd15, 8'h0D, "R10 pending bit");
    pulse(1);
    expReg(4'd1, 8'h00, "R10 round down sec");
    expReg(4'd2, 8'h10, "R10 round down min");
    expReg(4'd0, 8'h00, "R10 sub zeroed");
    expReg(4'd15, 8'h09, "R10 request cleared");
    loadTime(56'h45_59_05_00_01_01_00);
    wr(4'd15, 8'h09);
    wr(4'd15, 8'h0D);
    pulse(1);
    expReg(4'd1, 8'h00, "R10 round up sec");
    expReg(4'd2, 8'h00, "R10 round up min");
    expReg(4'd3, 8'h06, "R10 round up hr");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule